// File: doc/BRIEF.md
# Received Packet Transaction Counter

This block counts the packets received on one DMA channel. When the count reaches a target that software has programmed, it reports that the buffer receive is complete. Software sees a single 16-bit register location. A write to it always sets the target count. A read returns either the target or the live count, and the enable input chooses which one. A write-one clear input sets the live count back to zero between transfers.

A packet strobe advances the live count by one while counting is enabled. The count saturates at its maximum value. Once it equals a nonzero target it holds, so a transfer that is already complete stays complete until software clears it. The completion pulse is raised only when the endpoint qualifiers describe an OUT buffer in continuous receive mode with bulk transfer type, with data taken through the FIFO data port. Only the hardware reset affects the registers.

Top module: `rx_pkt_txn_counter`

## Requirements
- R1: After hardware reset (rst_n low), the target and the live count are both 0x0000 and done_pulse is 0.
- R2: When reg_wr is high at a clock edge, the target is loaded from reg_wdata. While cnt_en is 0, reg_rdata shows the target.
- R3: While cnt_en is 1, reg_rdata shows the live count. live_count always shows the live count.
- R4: Each clock edge with pkt_rx=1 and cnt_en=1 raises the live count by exactly one. With cnt_en=0 a strobe leaves the count unchanged.
- R5: done_pulse is high for exactly the one cycle after the edge at which an increment makes the live count equal to the target. This happens only when ep_is_out=1, rx_continuous=1, xfer_type=2'b01 (bulk) and fifo_port_path=1.
- R6: If any one of the four qualifiers in R5 is not met, no completion pulse is raised, but the count still advances.
- R7: cnt_clr=1 at an edge makes the live count 0x0000. If pkt_rx is high in the same cycle, the clear takes priority. cnt_clr=0 has no effect.
- R8: A target of 0x0000 never produces a completion pulse.
- R9: The live count saturates at 0xFFFF and does not wrap.
- R10: Once the live count equals a nonzero target, further strobes leave it unchanged until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_wr | input | 1 | Register write strobe (loads target) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (target or live count) |
| cnt_en | input | 1 | Counting enable; also selects the read source |
| cnt_clr | input | 1 | Write-one clear of the live count |
| pkt_rx | input | 1 | One-cycle strobe per received packet |
| ep_is_out | input | 1 | Endpoint is an OUT buffer |
| rx_continuous | input | 1 | Continuous receive mode selected |
| xfer_type | input | 2 | Transfer type code; 2'b01 is bulk |
| fifo_port_path | input | 1 | Data accessed through the FIFO data port |
| done_pulse | output | 1 | One-cycle receive-complete pulse |
| live_count | output | 16 | Current received-packet count |

## Verification
A corrupted live count shows up on live_count one cycle after the faulty edge. With the enable set, it also appears on reg_rdata in that cycle. A corrupted target stays hidden while counting is enabled, but it appears on reg_rdata as soon as the enable drops. It also moves the completion pulse, or suppresses it, on the strobe that should have matched. A fault in the qualifier gating or the compare is only visible in the cycle after the matching strobe, so the bench samples every strobe step as well as each qualifier on its own.

// File: rtl/txn_pkg.sv
package txn_pkg;
  localparam int CNT_W = 16;
  localparam logic [1:0] BULK_CODE = 2'b01;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  function automatic logic qual_ok(input logic is_out, input logic cont,
                                   input logic [1:0] typ, input logic fifo);
    return is_out && cont && (typ == BULK_CODE) && fifo;
  endfunction
endpackage

// File: rtl/txn_target_reg.sv
module txn_target_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] target
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    target <= '0;
    else if (load) target <= din;
  end
endmodule

// File: rtl/txn_live_counter.sv
module txn_live_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         strobe,
  input  logic [W-1:0] target,
  output logic [W-1:0] count,
  output logic         inc_fire
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic frozen;

  assign frozen   = (target != '0) && (count == target);
  assign inc_fire = strobe && en && !clr && !frozen && (count != MAXV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (clr)      count <= '0;
    else if (inc_fire) count <= count + 1'b1;
  end
endmodule

// File: rtl/txn_done_gate.sv
module txn_done_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_fire,
  input  logic [W-1:0] count,
  input  logic [W-1:0] target,
  input  logic         qualified,
  output logic         done
);
  logic hit;
  assign hit = inc_fire && qualified && (target != '0) && (txn_pkg::sat_inc(count) == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= hit;
  end
endmodule

// File: rtl/rx_pkt_txn_counter.sv
module rx_pkt_txn_counter #(
  parameter int CNT_W = txn_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             cnt_en,
  input  logic             cnt_clr,
  input  logic             pkt_rx,
  input  logic             ep_is_out,
  input  logic             rx_continuous,
  input  logic [1:0]       xfer_type,
  input  logic             fifo_port_path,
  output logic             done_pulse,
  output logic [CNT_W-1:0] live_count
);
  logic [CNT_W-1:0] target_q;
  logic             inc_fire;
  logic             qualified;

  assign qualified = txn_pkg::qual_ok(ep_is_out, rx_continuous, xfer_type, fifo_port_path);

  txn_target_reg #(.W(CNT_W)) u_target (
    .clk(clk), .rst_n(rst_n), .load(reg_wr), .din(reg_wdata), .target(target_q)
  );

  txn_live_counter #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(cnt_clr), .strobe(pkt_rx),
    .target(target_q), .count(live_count), .inc_fire(inc_fire)
  );

  txn_done_gate #(.W(CNT_W)) u_done (
    .clk(clk), .rst_n(rst_n), .inc_fire(inc_fire), .count(live_count),
    .target(target_q), .qualified(qualified), .done(done_pulse)
  );

  assign reg_rdata = cnt_en ? live_count : target_q;
endmodule

// File: rtl/txn_counter_checker.sv
module txn_counter_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             cnt_clr,
  input logic             pkt_rx,
  input logic [CNT_W-1:0] reg_rdata,
  input logic [CNT_W-1:0] live_count,
  input logic [CNT_W-1:0] target_q,
  input logic             done_pulse
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (live_count == '0));

  assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_clr) |=> $stable(live_count));

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (live_count == $past(live_count) || live_count == $past(live_count) + 1'b1));

  assert_read_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |-> (reg_rdata == live_count));

  assert_read_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> (reg_rdata == target_q));

  assert_done_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (live_count == target_q));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  assert_zero_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (target_q != '0));

  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_count == MAXV && !cnt_clr) |=> (live_count == MAXV));
endmodule

bind rx_pkt_txn_counter txn_counter_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr), .pkt_rx(pkt_rx),
  .reg_rdata(reg_rdata), .live_count(live_count), .target_q(target_q),
  .done_pulse(done_pulse)
);

// File: tb/rx_pkt_txn_counter_tb.sv
module rx_pkt_txn_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] QG = 5'b1_1_01_1; // out, continuous, bulk, fifo

  typedef struct packed {
    logic        wr;
    logic [15:0] wdata;
    logic        en;
    logic        clr;
    logic        pkt;
    logic [4:0]  q;
    logic [15:0] ecount;
    logic        edone;
    logic [15:0] erd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 16'd3, 1'b0, 1'b0, 1'b0, QG,       16'd0, 1'b0, 16'd3}, // R2
    '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, QG,       16'd1, 1'b0, 16'd1}, // R4 R3
    '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, QG,       16'd1, 1'b0, 16'd1}, // R4
    '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, QG,       16'd2, 1'b0, 16'd2}, // R4
    '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, QG,       16'd3, 1'b1, 16'd3}, // R5
    '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, QG,       16'd3, 1'b0, 16'd3}, // R10
    '{1'b0, 16'd0, 1'b0, 1'b0, 1'b0, QG,       16'd3, 1'b0, 16'd3}, // R2
    '{1'b0, 16'd0, 1'b1, 1'b1, 1'b0, QG,       16'd0, 1'b0, 16'd0}, // R7
    '{1'b0, 16'd0, 1'b1, 1'b1, 1'b1, QG,       16'd0, 1'b0, 16'd0}, // R7 priority
    '{1'b0, 16'd0, 1'b0, 1'b0, 1'b1, QG,       16'd0, 1'b0, 16'd3}, // R4 disabled
    '{1'b1, 16'd2, 1'b1, 1'b0, 1'b1, 5'b11101, 16'd1, 1'b0, 16'd1}, // R6
    '{1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 5'b11101, 16'd2, 1'b0, 16'd2}, // R6
    '{1'b0, 16'd0, 1'b0, 1'b0, 1'b0, QG,       16'd2, 1'b0, 16'd2}, // R2
    '{1'b0, 16'd0, 1'b1, 1'b0, 1'b0, QG,       16'd2, 1'b0, 16'd2}  // R7 clr=0 no effect
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, cnt_en = 0, cnt_clr = 0, pkt_rx = 0;
  logic [15:0] reg_wdata = 0;
  logic ep_is_out = 0, rx_continuous = 0, fifo_port_path = 0;
  logic [1:0] xfer_type = 0;
  logic [15:0] reg_rdata, live_count;
  logic done_pulse;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pkt_txn_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cnt_en(cnt_en), .cnt_clr(cnt_clr), .pkt_rx(pkt_rx),
    .ep_is_out(ep_is_out), .rx_continuous(rx_continuous), .xfer_type(xfer_type),
    .fifo_port_path(fifo_port_path), .done_pulse(done_pulse), .live_count(live_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [15:0] wd, input logic en,
                       input logic clr, input logic pkt, input logic [4:0] q);
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd; cnt_en = en; cnt_clr = clr; pkt_rx = pkt;
    {ep_is_out, rx_continuous, xfer_type, fifo_port_path} = q;
    @(posedge clk); #1;
    reg_wr = 0; cnt_clr = 0; pkt_rx = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int dones;
    repeat (3) @(posedge clk);
    #1;
    check("R1 count", live_count, 0);
    check("R1 rdata", reg_rdata, 0);
    check("R1 done", done_pulse, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].wr, TBL[i].wdata, TBL[i].en, TBL[i].clr, TBL[i].pkt, TBL[i].q);
      check($sformatf("R2-R10 vec%0d count", i), live_count, TBL[i].ecount);
      check($sformatf("R5 vec%0d done", i), done_pulse, TBL[i].edone);
      check($sformatf("R3 vec%0d rdata", i), reg_rdata, TBL[i].erd);
    end

    // R6: each qualifier off in turn, target 1
    for (int k = 0; k < 5; k++) begin
      logic [4:0] q;
      q = QG;
      if (k < 2) q[4-k] = 1'b0;
      else if (k == 2) q[2:1] = 2'b00;
      else if (k == 3) q[2:1] = 2'b11;
      else q[0] = 1'b0;
      drive(1'b1, 16'd1, 1'b1, 1'b1, 1'b0, QG);
      drive(1'b0, 16'd0, 1'b1, 1'b0, 1'b1, q);
      check($sformatf("R6 qual%0d done", k), done_pulse, 0);
      check($sformatf("R6 qual%0d count", k), live_count, 1);
    end

    // R8: target zero never completes, R9 saturation
    drive(1'b1, 16'd0, 1'b1, 1'b1, 1'b0, QG);
    dones = 0;
    for (int j = 0; j < 65540; j++) begin
      drive(1'b0, 16'd0, 1'b1, 1'b0, 1'b1, QG);
      if (done_pulse) dones++;
      if (j == 2) check("R8 count after 3", live_count, 3);
    end
    check("R8 no done", dones, 0);
    check("R9 saturated", live_count, 16'hFFFF);

    // R7 clear after saturation; R1 reset clears target
    drive(1'b0, 16'd0, 1'b1, 1'b1, 1'b0, QG);
    check("R7 clear from max", live_count, 0);
    drive(1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, QG);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1 target reset", reg_rdata, 0);
    finish_run();
  end
endmodule